// File: doc/BRIEF.md
# Class-D Switching Clock Generator

This block produces the switching-rate tick for a Class-D output stage, running entirely on one system clock. It offers three tick sources. The first is locked to an audio sample-rate strobe, so that several output stages fed from one audio clock switch in step. The second is a free-running phase-accumulator oscillator at one of two base rates. The third is the same oscillator with its increment swept in a triangle around a 384 kHz centre, which spreads the switching energy across the spectrum.

The three configuration fields are read only when the power-up enable rises. Changes made while the channel is up are ignored until the next power-down and power-up. Besides the tick, the block drives a sawtooth phase value for a downstream ramp model and a flag that shows the channel is up.

Top module: `clsd_swclk_gen`

## Requirements
- R1: While reset is asserted, and until the first power-up, `tick_o` and `active_o` are 0 and `phase_o` is 0.
- R2: The fields `mode_sel_i`, `rate_sel_i` and `depth_sel_i` are captured on the clock edge where `en_i` is 1 and the block was powered down. `active_o` is 1 from that edge until the edge where `en_i` is sampled 0. Field changes while `active_o` is 1 have no effect.
- R3: Reserved codes are replaced when they are captured. Mode 2'b11 behaves as 2'b00 (sync). Rate 2'b10 and 2'b11 behave as 2'b00 (384 kHz). Depth 2'b00 and 2'b11 behave as 2'b01 (±5 %).
- R4: In sync mode (mode 2'b00), a strobe edge emits a tick in the following cycle, and then 7 further ticks spaced S cycles apart. S = max(1, floor(P/8)), where P is the number of cycles between this strobe and the previous one. The first strobe after power-up emits no ticks.
- R5: In sync mode, a strobe that arrives before the 8 ticks are complete cuts the running sequence short and starts a new one at once.
- R6: In fixed mode (mode 2'b01), an ACC_W-bit accumulator adds round(f·2^ACC_W / SYS_CLK_HZ) on every active cycle. f is 384 kHz for rate 2'b00 and 352.8 kHz for rate 2'b01. Each wrap gives one tick in the next cycle.
- R7: In spread mode (mode 2'b10), the increment is the 384 kHz increment plus (k−HALF_STEPS)·step. The step is (increment·pct/100)/HALF_STEPS, with pct = 5 for depth 2'b01 and 10 for depth 2'b10. k starts at HALF_STEPS and rises. k moves by one every SYS_CLK_HZ/(MOD_HZ·4·HALF_STEPS) cycles and turns around at 0 and 2·HALF_STEPS.
- R8: `phase_o` is the top PHASE_W bits of the accumulator in fixed and spread modes. In sync mode it is the number of cycles since the last tick or since power-up, saturating at 2^PHASE_W−1.
- R9: When `en_i` is sampled 0, the next edge clears the tick, the accumulator, the phase and the sync strobe history. Strobes have no effect while the block is powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel power-up enable |
| fs_stb_i | input | 1 | One-cycle sample-rate strobe |
| mode_sel_i | input | 2 | Tick source: 00 sync, 01 fixed, 10 spread, 11 reserved |
| rate_sel_i | input | 2 | Base rate: 00 384 kHz, 01 352.8 kHz, others reserved |
| depth_sel_i | input | 2 | Spread depth: 01 ±5 %, 10 ±10 %, others reserved |
| tick_o | output | 1 | Switching tick, one cycle per period |
| phase_o | output | PHASE_W | Ramp phase value |
| active_o | output | 1 | Channel is powered up |

## Verification
The embedded assertions check the following on every cycle:
- the captured configuration stays stable while the channel is up, and never holds a reserved code;
- a tick is only ever seen while the block is active;
- an oscillator tick only follows an accumulator wrap;
- the sync sequence index and the triangle index stay in range and move by at most one step;
- the state is cleared at the edge after the enable drops.

Some behaviour only the bench scenarios can show:
- exactly eight ticks per strobe interval, and the shortened count after an early strobe;
- the long-run tick counts that separate the two base rates;
- the wider spread of tick intervals at the deeper modulation setting;
- that reserved codes fall back to their defaults.

// File: rtl/clsd_swclk_pkg.sv
package clsd_swclk_pkg;

  typedef enum logic [1:0] {
    SW_MODE_SYNC   = 2'b00,
    SW_MODE_FIXED  = 2'b01,
    SW_MODE_SPREAD = 2'b10
  } sw_mode_e;

  typedef struct packed {
    sw_mode_e mode;
    logic     alt_rate;  // 352.8 kHz base instead of 384 kHz
    logic     wide_dev;  // +-10 % spread instead of +-5 %
  } sw_cfg_t;

  localparam sw_cfg_t SW_CFG_DEFAULT = '{mode: SW_MODE_SYNC, alt_rate: 1'b0, wide_dev: 1'b0};

  function automatic sw_cfg_t sw_cfg_clean(input logic [1:0] mode_raw,
                                           input logic [1:0] rate_raw,
                                           input logic [1:0] depth_raw);
    sw_cfg_t c;
    c.mode     = (mode_raw == 2'b11) ? SW_MODE_SYNC : sw_mode_e'(mode_raw);
    c.alt_rate = (rate_raw == 2'b01);
    c.wide_dev = (depth_raw == 2'b10);
    return c;
  endfunction

endpackage

// File: rtl/swclk_cfg_latch.sv
module swclk_cfg_latch
  import clsd_swclk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] mode_raw_i,
  input  logic [1:0] rate_raw_i,
  input  logic [1:0] depth_raw_i,
  output logic       pwr_o,
  output sw_cfg_t    cfg_o
);

  logic    pwr_q;
  sw_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q <= 1'b0;
      cfg_q <= SW_CFG_DEFAULT;
    end else begin
      pwr_q <= en_i;
      if (en_i && !pwr_q) cfg_q <= sw_cfg_clean(mode_raw_i, rate_raw_i, depth_raw_i);
    end
  end

  assign pwr_o = pwr_q;
  assign cfg_o = cfg_q;

  assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_q && $past(pwr_q)) |-> $stable(cfg_q));

  assert_cfg_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.mode != 2'b11);

endmodule

// File: rtl/swclk_sync_div.sv
module swclk_sync_div #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PHASE_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               stb_i,
  output logic               tick_o,
  output logic [PHASE_W-1:0] phase_o
);

  localparam int unsigned TICKS = 8;
  localparam logic [CNT_W-1:0] PH_MAX = CNT_W'((2 ** PHASE_W) - 1);

  logic [CNT_W-1:0] per_cnt, spacing, sub;
  logic [3:0]       idx;     // ticks issued in current sequence, TICKS = done
  logic             seen, tick_q;
  logic [CNT_W:0]   per_p1;
  logic [CNT_W-1:0] sp_new;
  logic             sub_hit;

  assign per_p1  = {1'b0, per_cnt} + 1'b1;
  assign sp_new  = ((per_p1 >> 3) == '0) ? CNT_W'(1) : CNT_W'(per_p1 >> 3);
  assign sub_hit = (idx < 4'(TICKS)) && (sub == spacing - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_cnt <= '0;
      spacing <= CNT_W'(1);
      sub     <= '0;
      idx     <= 4'(TICKS);
      seen    <= 1'b0;
      tick_q  <= 1'b0;
    end else if (!run_i) begin
      per_cnt <= '0;
      sub     <= '0;
      idx     <= 4'(TICKS);
      seen    <= 1'b0;
      tick_q  <= 1'b0;
    end else if (stb_i) begin
      per_cnt <= '0;
      seen    <= 1'b1;
      if (seen) begin
        spacing <= sp_new;
        idx     <= 4'd1;
        sub     <= '0;
        tick_q  <= 1'b1;
      end else begin
        sub    <= (sub == '1) ? sub : sub + 1'b1;
        tick_q <= 1'b0;
      end
    end else begin
      per_cnt <= (per_cnt == '1) ? per_cnt : per_cnt + 1'b1;
      if (sub_hit) begin
        idx    <= idx + 1'b1;
        sub    <= '0;
        tick_q <= 1'b1;
      end else begin
        sub    <= (sub == '1) ? sub : sub + 1'b1;
        tick_q <= 1'b0;
      end
    end
  end

  assign tick_o  = tick_q;
  assign phase_o = (sub > PH_MAX) ? PH_MAX[PHASE_W-1:0] : sub[PHASE_W-1:0];

  assert_sync_seq_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx >= 4'd1) && (idx <= 4'(TICKS)));

  assert_sync_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!tick_q && sub == '0));

endmodule

// File: rtl/swclk_ssm_tri.sv
module swclk_ssm_tri #(
  parameter int unsigned ACC_W      = 32,
  parameter int unsigned HALF_STEPS = 16,
  parameter int unsigned STEP_CYC   = 390,
  parameter logic [ACC_W-1:0] STEP_N = '0,
  parameter logic [ACC_W-1:0] STEP_W = '0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic                    wide_i,
  output logic signed [ACC_W-1:0] offset_o
);

  localparam int unsigned KW    = $clog2(2 * HALF_STEPS + 1);
  localparam int unsigned DIV_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [KW-1:0] K_MID = KW'(HALF_STEPS);
  localparam logic [KW-1:0] K_TOP = KW'(2 * HALF_STEPS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(STEP_CYC - 1);

  logic [KW-1:0]    k;
  logic             up;
  logic [DIV_W-1:0] div;
  logic signed [ACC_W-1:0] k_rel, step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k   <= K_MID;
      up  <= 1'b1;
      div <= '0;
    end else if (!run_i) begin
      k   <= K_MID;
      up  <= 1'b1;
      div <= '0;
    end else if (div == DIV_LAST) begin
      div <= '0;
      if (up) begin
        k <= k + 1'b1;
        if (k + 1'b1 == K_TOP) up <= 1'b0;
      end else begin
        k <= k - 1'b1;
        if (k - 1'b1 == '0) up <= 1'b1;
      end
    end else begin
      div <= div + 1'b1;
    end
  end

  assign k_rel    = ACC_W'(k) - ACC_W'(K_MID);
  assign step     = wide_i ? STEP_W : STEP_N;
  assign offset_o = k_rel * step;

  assert_tri_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k <= K_TOP);

  assert_tri_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |->
      (k == $past(k) || k == KW'($past(k) + 1'b1) || k == KW'($past(k) - 1'b1)));

endmodule

// File: rtl/swclk_phase_osc.sv
module swclk_phase_osc #(
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned PHASE_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [ACC_W-1:0]   inc_i,
  output logic               tick_o,
  output logic [PHASE_W-1:0] phase_o
);

  logic [ACC_W-1:0] acc;
  logic             tick_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc} + {1'b0, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc    <= '0;
      tick_q <= 1'b0;
    end else if (!run_i) begin
      acc    <= '0;
      tick_q <= 1'b0;
    end else begin
      acc    <= sum[ACC_W-1:0];
      tick_q <= sum[ACC_W];
    end
  end

  assign tick_o  = tick_q;
  assign phase_o = acc[ACC_W-1 -: PHASE_W];

  assert_osc_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> (acc < $past(acc)));

  assert_osc_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (acc == '0 && !tick_q));

endmodule

// File: rtl/clsd_swclk_gen.sv
module clsd_swclk_gen
  import clsd_swclk_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ     = 100_000_000,
  parameter int unsigned RATE_A_HZ      = 384_000,
  parameter int unsigned RATE_B_HZ      = 352_800,
  parameter int unsigned MOD_HZ         = 4_000,
  parameter int unsigned HALF_STEPS     = 16,
  parameter int unsigned DEV_NARROW_PCT = 5,
  parameter int unsigned DEV_WIDE_PCT   = 10,
  parameter int unsigned ACC_W          = 32,
  parameter int unsigned PHASE_W        = 10,
  parameter int unsigned CNT_W          = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               fs_stb_i,
  input  logic [1:0]         mode_sel_i,
  input  logic [1:0]         rate_sel_i,
  input  logic [1:0]         depth_sel_i,
  output logic               tick_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               active_o
);

  localparam logic [63:0] INC_A_L =
    ((64'(RATE_A_HZ) << ACC_W) + 64'(SYS_CLK_HZ / 2)) / 64'(SYS_CLK_HZ);
  localparam logic [63:0] INC_B_L =
    ((64'(RATE_B_HZ) << ACC_W) + 64'(SYS_CLK_HZ / 2)) / 64'(SYS_CLK_HZ);
  localparam logic [ACC_W-1:0] INC_A  = ACC_W'(INC_A_L);
  localparam logic [ACC_W-1:0] INC_B  = ACC_W'(INC_B_L);
  localparam logic [ACC_W-1:0] STEP_N = ACC_W'(INC_A_L * DEV_NARROW_PCT / 100 / HALF_STEPS);
  localparam logic [ACC_W-1:0] STEP_W = ACC_W'(INC_A_L * DEV_WIDE_PCT / 100 / HALF_STEPS);
  localparam int unsigned STEP_CYC = SYS_CLK_HZ / (MOD_HZ * 4 * HALF_STEPS);

  logic    pwr;
  sw_cfg_t cfg;
  logic    run_any, run_sync, run_osc, run_ssm;
  logic    sync_tick, osc_tick;
  logic [PHASE_W-1:0] sync_ph, osc_ph;
  logic signed [ACC_W-1:0] ssm_off;
  logic [ACC_W-1:0] inc;

  swclk_cfg_latch u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .mode_raw_i  (mode_sel_i),
    .rate_raw_i  (rate_sel_i),
    .depth_raw_i (depth_sel_i),
    .pwr_o       (pwr),
    .cfg_o       (cfg)
  );

  assign run_any  = pwr && en_i;
  assign run_sync = run_any && (cfg.mode == SW_MODE_SYNC);
  assign run_osc  = run_any && (cfg.mode != SW_MODE_SYNC);
  assign run_ssm  = run_any && (cfg.mode == SW_MODE_SPREAD);

  swclk_sync_div #(.CNT_W(CNT_W), .PHASE_W(PHASE_W)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_sync),
    .stb_i   (fs_stb_i),
    .tick_o  (sync_tick),
    .phase_o (sync_ph)
  );

  swclk_ssm_tri #(
    .ACC_W(ACC_W), .HALF_STEPS(HALF_STEPS), .STEP_CYC(STEP_CYC),
    .STEP_N(STEP_N), .STEP_W(STEP_W)
  ) u_tri (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_ssm),
    .wide_i   (cfg.wide_dev),
    .offset_o (ssm_off)
  );

  // spread mode always centres on rate A
  always_comb begin
    if (cfg.mode == SW_MODE_SPREAD) inc = INC_A + ssm_off;
    else if (cfg.alt_rate)          inc = INC_B;
    else                            inc = INC_A;
  end

  swclk_phase_osc #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_osc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_osc),
    .inc_i   (inc),
    .tick_o  (osc_tick),
    .phase_o (osc_ph)
  );

  assign tick_o   = sync_tick | osc_tick;
  assign phase_o  = (cfg.mode == SW_MODE_SYNC) ? sync_ph : osc_ph;
  assign active_o = pwr;

  assert_tick_active_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> active_o);

  assert_single_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sync_tick && osc_tick));

endmodule

// File: tb/sim_clsd_swclk_gen.sv
module sim_clsd_swclk_gen;

  localparam longint SYS   = 100_000_000;
  localparam longint TWO32 = 64'd1 << 32;
  localparam longint I384  = (384_000 * TWO32 + SYS / 2) / SYS;
  localparam longint I353  = (352_800 * TWO32 + SYS / 2) / SYS;
  localparam longint ST5   = I384 * 5 / 100 / 16;
  localparam longint ST10  = I384 * 10 / 100 / 16;
  localparam int     HALF  = 16;
  localparam int     SCYC  = 100_000_000 / (4_000 * 4 * 16);

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en = 1'b0, stb = 1'b0;
  logic [1:0] mode = 2'b00, rate = 2'b00, depth = 2'b01;
  logic       tick_o, active_o;
  logic [9:0] phase_o;

  int n_cmp = 0, n_bad = 0, n_print = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clsd_swclk_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .fs_stb_i(stb),
    .mode_sel_i(mode), .rate_sel_i(rate), .depth_sel_i(depth),
    .tick_o(tick_o), .phase_o(phase_o), .active_o(active_o)
  );

  // ---------------- reference model ----------------
  longint n_edge, s_last, s_start, s_sp, acc;
  bit     m_pwr, m_wide, s_seen, s_seq, up, e_tick, e_act;
  int     m_mode, m_rate, s_ph, k, dv, e_ph;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      n_edge = 0; m_pwr = 0; m_mode = 0; m_rate = 0; m_wide = 0;
      s_seen = 0; s_seq = 0; s_last = 0; s_start = 0; s_sp = 1; s_ph = 0;
      acc = 0; k = HALF; up = 1; dv = 0;
      e_tick = 0; e_act = 0; e_ph = 0;
    end else begin
      bit run, tk;
      longint inc;
      n_edge++;
      run = m_pwr && en;
      tk  = 0;
      if (run && m_mode == 0) begin
        if (stb) begin
          if (s_seen) begin
            s_sp = (n_edge - s_last) / 8;
            if (s_sp < 1) s_sp = 1;
            s_start = n_edge; s_seq = 1; tk = 1;
          end
          s_seen = 1; s_last = n_edge;
        end else if (s_seq) begin
          longint d;
          d = n_edge - s_start;
          if (d % s_sp == 0) begin
            if (d / s_sp <= 7) tk = 1;
            if (d / s_sp >= 7) s_seq = 0;
          end
        end
        s_ph = tk ? 0 : ((s_ph < 1023) ? s_ph + 1 : 1023);
      end else begin
        s_seen = 0; s_seq = 0; s_ph = 0;
      end
      if (run && m_mode != 0) begin
        if (m_mode == 2)      inc = I384 + longint'(k - HALF) * (m_wide ? ST10 : ST5);
        else if (m_rate == 1) inc = I353;
        else                  inc = I384;
        acc = acc + inc;
        if (acc >= TWO32) begin tk = 1; acc = acc - TWO32; end
      end else acc = 0;
      if (run && m_mode == 2) begin
        if (dv == SCYC - 1) begin
          dv = 0;
          if (up) begin k++; if (k == 2 * HALF) up = 0; end
          else    begin k--; if (k == 0) up = 1; end
        end else dv++;
      end else begin k = HALF; up = 1; dv = 0; end
      if (en && !m_pwr) begin
        m_mode = (mode == 2'b11) ? 0 : int'(mode);
        m_rate = (rate == 2'b01) ? 1 : 0;
        m_wide = (depth == 2'b10);
      end
      m_pwr  = en;
      e_tick = tk;
      e_act  = m_pwr;
      e_ph   = (m_mode == 0) ? s_ph : int'(acc >> 22);
    end
  end

  // ---------------- per-cycle compare ----------------
  always @(negedge clk) begin
    if (!done) begin
      string req;
      n_cmp++;
      req = (m_mode == 0) ? "R4" : (m_mode == 1) ? "R6" : "R7";
      if (tick_o !== e_tick || active_o !== e_act || phase_o !== 10'(e_ph)) begin
        n_bad++;
        if (n_print < 12) begin
          n_print++;
          if (tick_o !== e_tick)
            $display("FAIL %s tick at edge %0d: got %0b exp %0b", req, n_edge, tick_o, e_tick);
          else if (active_o !== e_act)
            $display("FAIL R2 active at edge %0d: got %0b exp %0b", n_edge, active_o, e_act);
          else
            $display("FAIL R8 phase at edge %0d: got %0d exp %0d", n_edge, phase_o, e_ph);
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic set_power(input bit on);
    @(negedge clk);
    en = on;
    repeat (5) @(negedge clk);
  endtask

  task automatic interval(input int gap, output int n);
    n = 0;
    stb = 1'b1;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      stb = 1'b0;
      n += int'(tick_o);
    end
  endtask

  task automatic window(input int cyc, output int n, output int mn, output int mx, output int mph);
    int last, gap;
    n = 0; mn = 1_000_000; mx = 0; mph = 0; last = -1;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (int'(phase_o) > mph) mph = int'(phase_o);
      if (tick_o) begin
        if (last >= 0) begin
          gap = i - last;
          if (gap < mn) mn = gap;
          if (gap > mx) mx = gap;
        end
        last = i;
        n++;
      end
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int n, mn, mx, mph;
    repeat (4) @(negedge clk);
    chk(tick_o == 0 && active_o == 0 && phase_o == 0, "R1 reset outputs", {tick_o, active_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(active_o == 0 && phase_o == 0, "R1 idle after reset", active_o, 0);

    // sync mode
    mode = 2'b00; rate = 2'b00; depth = 2'b01;
    set_power(1);
    chk(active_o == 1, "R2 active after power-up", active_o, 1);
    interval(2083, n); chk(n == 0, "R4 first strobe silent", n, 0);
    interval(2083, n); chk(n == 8, "R4 eight ticks", n, 8);
    mode = 2'b01; rate = 2'b01; depth = 2'b10;  // ignored while up
    interval(2083, n); chk(n == 8, "R2 change ignored", n, 8);
    interval(1000, n); chk(n == 4, "R5 early strobe cuts sequence", n, 4);
    interval(2083, n); chk(n == 8, "R5 new spacing still eight", n, 8);

    // power-down
    set_power(0);
    chk(active_o == 0 && tick_o == 0 && phase_o == 0, "R9 cleared on power-down", active_o, 0);
    interval(300, n); chk(n == 0, "R9 strobes ignored when down", n, 0);

    // fixed 384 kHz
    mode = 2'b01; rate = 2'b00;
    set_power(1);
    window(12000, n, mn, mx, mph);
    chk(n >= 45 && n <= 47, "R6 fixed 384k count", n, 46);
    chk(mph >= 1000, "R8 sawtooth spans range", mph, 1000);
    set_power(0);

    // fixed 352.8 kHz
    rate = 2'b01;
    set_power(1);
    window(12000, n, mn, mx, mph);
    chk(n >= 41 && n <= 43, "R6 fixed 352.8k count", n, 42);
    set_power(0);

    // spread +-5 %
    mode = 2'b10; rate = 2'b01; depth = 2'b01;
    set_power(1);
    window(26000, n, mn, mx, mph);
    chk(n >= 97 && n <= 102, "R7 spread5 mean rate", n, 100);
    chk(mx - mn >= 20 && mx - mn <= 32, "R7 spread5 interval range", mx - mn, 26);
    set_power(0);

    // spread +-10 %
    depth = 2'b10;
    set_power(1);
    window(26000, n, mn, mx, mph);
    chk(mx - mn >= 45 && mx - mn <= 60, "R7 spread10 interval range", mx - mn, 53);
    set_power(0);

    // reserved codes
    mode = 2'b11; rate = 2'b00; depth = 2'b01;
    set_power(1);
    interval(2083, n);
    interval(2083, n); chk(n == 8, "R3 mode 11 acts as sync", n, 8);
    set_power(0);

    mode = 2'b01; rate = 2'b10;
    set_power(1);
    window(12000, n, mn, mx, mph);
    chk(n >= 45 && n <= 47, "R3 rate 10 acts as 384k", n, 46);
    set_power(0);

    mode = 2'b10; depth = 2'b00;
    set_power(1);
    window(26000, n, mn, mx, mph);
    chk(mx - mn >= 20 && mx - mn <= 32, "R3 depth 00 acts as 5pct", mx - mn, 26);
    set_power(0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout exp finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule